// File: doc/BRIEF.md
# Grouped Pin Interrupt Summary with End-of-Interrupt Re-arm

This block condenses a large set of per-pin pending signals into a compact summary that a host can scan quickly. Pins are taken in groups of four. Each group sets one summary bit, so 184 pins fold into 46 bits. The host reads these bits as a low and a high 32-bit word. A single shared interrupt line goes to the host. The line pulses once when a summary bit is set, and it stays quiet until software writes an end-of-interrupt (EOI) command to the master control register.

The master register also controls a global blanking window. When the block-enable bit is set, any write to any pin's debounce configuration starts the window. While the window is open, the block generates no status for any pin: the summary reads as zero, and a flag tells the register file to return the per-pin interrupt-enable bits as 0. The window length is a 12-bit count of RTC ticks. A further debounce write while the window is open starts the count again.

Two state machines run the block. The line machine has three states. ARMED waits for a non-empty summary. FIRE drives the line high for one cycle. WAIT keeps the line low until EOI. Its transitions are as follows. ARMED goes to FIRE on a non-empty summary. FIRE goes to ARMED if EOI arrives in that cycle, and to WAIT otherwise. WAIT goes to FIRE on EOI with a non-empty summary, and to ARMED on EOI with an empty one. The blanking machine has two states, OPEN and BLANK. OPEN goes to BLANK on a triggering debounce write with a non-zero length. BLANK goes back to OPEN when the count runs out on a tick, or when a new trigger arrives with length zero. In BLANK, a new trigger reloads the count.

Top module: `pin_irq_summary`

## Requirements
- R1: After reset, both summary words are 0, the line is low, the blanking flag is low and the master register reads 0.
- R2: One cycle after the pending inputs are sampled, summary bit n is the OR of the pending inputs of pins 4n to 4n+3. Bits 0 to 31 appear in `sum_lo`, and bits 32 to 45 appear in `sum_hi` bits 0 to 13.
- R3: Bits 14 to 31 of `sum_hi` always read 0.
- R4: When armed, the line goes high for exactly one cycle, in the cycle after it sees a non-zero summary. It then stays low until EOI.
- R5: A master write with bit 13 set is an EOI and re-arms the line. If the summary is non-zero when the EOI is taken, the line goes high in the next cycle.
- R6: The master register reads back the length in bits 11:0 and the block-enable in bit 12. Bit 13 (EOI) and all higher bits always read 0.
- R7: A debounce write to any pin while the block-enable is 1 and the length is L>0 raises `en_block` for L RTC ticks. From the second cycle of the window, both summary words read 0 and pending inputs are ignored.
- R8: A debounce write while the block-enable is 0 opens no window.
- R9: A debounce write while the window is open reloads the count to the current length.
- R10: A debounce write with length 0 opens no window, even when the block-enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_pend | input | 184 | Per-pin pending signals |
| dbnc_wr | input | 184 | Per-pin strobes for debounce-configuration writes |
| rtc_tick | input | 1 | One-cycle pulse for each RTC tick |
| mst_wr | input | 1 | Master register write strobe |
| mst_wdata | input | 32 | Master write data: [11:0] length, [12] block-enable, [13] EOI |
| sum_lo | output | 32 | Summary bits 31:0 |
| sum_hi | output | 32 | Summary bits 45:32 in [13:0]; upper bits 0 |
| host_irq | output | 1 | Shared interrupt line to the host |
| en_block | output | 1 | High while the blanking window is open; per-pin enable bits must read 0 |
| mst_rdata | output | 32 | Master register readback |

## Verification
The hardest case to reach is a debounce write that lands inside a window which is already open. It must arrive after some ticks have elapsed and before the window ends, so that a reload can be told apart from a window that simply runs on. The bench sets a length of 8 ticks, with a tick every fourth cycle. It issues a second write 20 cycles into the window and then checks that the flag is still high well past the first window's end. A random phase follows: sparse pending patterns, scattered debounce strobes, and master writes that mix lengths, enables and EOIs. These are compared every cycle against a behavioural model, which also covers an EOI that lands in the same cycle as the one-cycle pulse.

// File: rtl/pis_pkg.sv
package pis_pkg;

    typedef enum logic [1:0] {
        L_ARMED = 2'd0,
        L_FIRE  = 2'd1,
        L_WAIT  = 2'd2
    } line_state_t;

    typedef enum logic {
        B_OPEN  = 1'b0,
        B_BLANK = 1'b1
    } blank_state_t;

endpackage

// File: rtl/pis_grouper.sv
module pis_grouper #(
    parameter int GROUP_W    = 4,
    parameter int NUM_GROUPS = 46,
    parameter int SUM_W      = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [GROUP_W*NUM_GROUPS-1:0] pend,
    input  logic                          blank,
    output logic [SUM_W-1:0]              summary
);
    logic [SUM_W-1:0] grouped;
    logic [SUM_W-1:0] sum_q;

    // Fold each group of pins into one summary bit; unused bits stay zero.
    generate
        for (genvar g = 0; g < SUM_W; g++) begin : g_bit
            if (g < NUM_GROUPS) begin : g_used
                assign grouped[g] = |pend[g*GROUP_W +: GROUP_W];
            end else begin : g_pad
                assign grouped[g] = 1'b0;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else if (blank) begin
            sum_q <= '0;
        end else begin
            sum_q <= grouped;
        end
    end

    assign summary = sum_q;
endmodule

// File: rtl/pis_blank_timer.sv
module pis_blank_timer
    import pis_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] len,
    input  logic             tick,
    output logic             blank
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    blank_state_t     state_q, state_d;
    logic [LEN_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            B_OPEN: begin
                if (start && (len != '0)) begin
                    state_d = B_BLANK;
                    cnt_d   = len;
                end
            end
            B_BLANK: begin
                if (start) begin
                    cnt_d   = len;
                    state_d = (len != '0) ? B_BLANK : B_OPEN;
                end else if (tick) begin
                    if (cnt_q == ONE) begin
                        state_d = B_OPEN;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
            end
            default: begin
                state_d = B_OPEN;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= B_OPEN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        blank = (state_q == B_BLANK);
    end
endmodule

// File: rtl/pis_line_fsm.sv
module pis_line_fsm
    import pis_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_pend,
    input  logic eoi,
    output logic irq
);
    line_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            L_ARMED: if (any_pend) state_d = L_FIRE;
            L_FIRE:  state_d = eoi ? L_ARMED : L_WAIT;
            L_WAIT: begin
                if (eoi) state_d = any_pend ? L_FIRE : L_ARMED;
            end
            default: state_d = L_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= L_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        irq = (state_q == L_FIRE);
    end
endmodule

// File: rtl/pin_irq_summary.sv
module pin_irq_summary #(
    parameter int GROUP_W    = 4,
    parameter int NUM_GROUPS = 46,
    parameter int WORD_W     = 32,
    parameter int LEN_W      = 12,
    parameter int NUM_PINS   = GROUP_W * NUM_GROUPS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_pend,
    input  logic [NUM_PINS-1:0] dbnc_wr,
    input  logic                rtc_tick,
    input  logic                mst_wr,
    input  logic [WORD_W-1:0]   mst_wdata,
    output logic [WORD_W-1:0]   sum_lo,
    output logic [WORD_W-1:0]   sum_hi,
    output logic                host_irq,
    output logic                en_block,
    output logic [WORD_W-1:0]   mst_rdata
);
    localparam int SUM_W   = 2 * WORD_W;
    localparam int BLK_BIT = LEN_W;
    localparam int EOI_BIT = LEN_W + 1;

    logic [LEN_W-1:0] len_q;
    logic             blk_en_q;
    logic             eoi;
    logic             start;
    logic             blank;
    logic [SUM_W-1:0] summary;

    // Master control register: length and block-enable are stored, EOI is a pulse.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q    <= '0;
            blk_en_q <= 1'b0;
        end else if (mst_wr) begin
            len_q    <= mst_wdata[LEN_W-1:0];
            blk_en_q <= mst_wdata[BLK_BIT];
        end
    end

    assign eoi   = mst_wr & mst_wdata[EOI_BIT];
    assign start = blk_en_q & (|dbnc_wr);

    pis_blank_timer #(.LEN_W(LEN_W)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .len   (len_q),
        .tick  (rtc_tick),
        .blank (blank)
    );

    pis_grouper #(
        .GROUP_W    (GROUP_W),
        .NUM_GROUPS (NUM_GROUPS),
        .SUM_W      (SUM_W)
    ) i_grouper (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend    (pin_pend),
        .blank   (blank),
        .summary (summary)
    );

    pis_line_fsm i_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .any_pend (|summary),
        .eoi      (eoi),
        .irq      (host_irq)
    );

    always_comb begin
        sum_lo    = summary[WORD_W-1:0];
        sum_hi    = summary[SUM_W-1:WORD_W];
        en_block  = blank;
        mst_rdata = '0;
        mst_rdata[LEN_W-1:0] = len_q;
        mst_rdata[BLK_BIT]   = blk_en_q;
    end
endmodule

// File: rtl/pis_chk.sv
module pis_chk #(
    parameter int WORD_W     = 32,
    parameter int NUM_GROUPS = 46,
    parameter int LEN_W      = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] sum_lo,
    input logic [WORD_W-1:0] sum_hi,
    input logic              host_irq,
    input logic              en_block,
    input logic [WORD_W-1:0] mst_rdata
);
    localparam int HI_VALID = NUM_GROUPS - WORD_W;

    AST_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_hi >> HI_VALID) == '0); // R3

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |=> !host_irq); // R4

    AST_IRQ_NEEDS_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_irq) |-> $past((sum_lo != '0) || (sum_hi != '0))); // R4

    AST_EOI_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        mst_rdata[LEN_W+1] == 1'b0); // R6

    AST_BLANK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (en_block && $past(en_block)) |-> (sum_lo == '0 && sum_hi == '0)); // R7

    AST_BLANK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_block) |-> $past(mst_rdata[LEN_W] && (mst_rdata[LEN_W-1:0] != '0))); // R8
endmodule

bind pin_irq_summary pis_chk #(
    .WORD_W     (WORD_W),
    .NUM_GROUPS (NUM_GROUPS),
    .LEN_W      (LEN_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sum_lo    (sum_lo),
    .sum_hi    (sum_hi),
    .host_irq  (host_irq),
    .en_block  (en_block),
    .mst_rdata (mst_rdata)
);

// File: tb/test_pin_irq_summary.sv
`timescale 1ns/1ps
module test_pin_irq_summary;
    localparam int NP = 184;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin_pend = '0;
    logic [NP-1:0] dbnc_wr = '0;
    logic          rtc_tick = 1'b0;
    logic          mst_wr = 1'b0;
    logic [31:0]   mst_wdata = '0;
    logic [31:0]   sum_lo, sum_hi, mst_rdata;
    logic          host_irq, en_block;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int div = 0;

    always #5 clk = ~clk;

    pin_irq_summary i_pin_irq_summary (
        .clk(clk), .rst_n(rst_n), .pin_pend(pin_pend), .dbnc_wr(dbnc_wr),
        .rtc_tick(rtc_tick), .mst_wr(mst_wr), .mst_wdata(mst_wdata),
        .sum_lo(sum_lo), .sum_hi(sum_hi), .host_irq(host_irq),
        .en_block(en_block), .mst_rdata(mst_rdata)
    );

    // Behavioural reference model
    logic [63:0] m_sum;
    int          m_cnt, m_len;
    bit          m_blk, m_irq, m_armed;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sum = '0; m_cnt = 0; m_len = 0; m_blk = 0; m_irq = 0; m_armed = 1;
        end else begin
            logic [63:0] s_n;
            int c_n;
            bit eoi, any, irq_n, arm_n;
            s_n = '0;
            if (m_cnt == 0)
                for (int g = 0; g < 46; g++) s_n[g] = |pin_pend[g*4 +: 4];
            c_n = m_cnt;
            if (m_blk && (|dbnc_wr)) c_n = m_len;
            else if (m_cnt != 0 && rtc_tick) c_n = m_cnt - 1;
            eoi = mst_wr && mst_wdata[13];
            any = (m_sum != 0);
            irq_n = m_irq; arm_n = m_armed;
            if (m_irq) begin
                irq_n = 0; arm_n = eoi;
            end else if (m_armed) begin
                if (any) begin irq_n = 1; arm_n = 0; end
            end else if (eoi) begin
                irq_n = any; arm_n = !any;
            end
            if (mst_wr) begin m_len = int'(mst_wdata[11:0]); m_blk = mst_wdata[12]; end
            m_sum = s_n; m_cnt = c_n; m_irq = irq_n; m_armed = arm_n;
        end
    end

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        div = (div + 1) % 4;
        rtc_tick = (div == 3);
        if (rst_n && !done) begin
            chk({32'h0, sum_lo}, {32'h0, m_sum[31:0]}, "R2 sum_lo");
            chk({32'h0, sum_hi}, {32'h0, m_sum[63:32]}, "R2/R3 sum_hi");
            chk({63'h0, host_irq}, {63'h0, m_irq}, "R4/R5 host_irq");
            chk({63'h0, en_block}, {63'h0, 1'(m_cnt != 0)}, "R7/R9 en_block");
            chk({32'h0, mst_rdata}, {32'h0, 19'h0, m_blk, 12'(m_len)}, "R6 mst_rdata");
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic mwrite(input logic [31:0] d);
        @(negedge clk); mst_wr = 1'b1; mst_wdata = d;
        @(negedge clk); mst_wr = 1'b0; mst_wdata = '0;
    endtask

    task automatic dwrite(input int pin);
        @(negedge clk); dbnc_wr[pin] = 1'b1;
        @(negedge clk); dbnc_wr = '0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk({sum_hi, sum_lo}, 64'h0, "R1 summary");
        chk({63'h0, host_irq}, 64'h0, "R1 irq");
        chk({63'h0, en_block}, 64'h0, "R1 block");
        chk({32'h0, mst_rdata}, 64'h0, "R1 rdata");

        // R2: group folding, low and high word placement
        @(negedge clk); pin_pend[2] = 1'b1; pin_pend[7] = 1'b1; pin_pend[183] = 1'b1;
        @(negedge clk);
        chk({32'h0, sum_lo}, 64'h3, "R2 groups 0 and 1");
        chk({32'h0, sum_hi}, 64'h2000, "R2 group 45 in high word");
        chk({63'h0, host_irq}, 64'h0, "R4 not yet");
        @(negedge clk);
        chk({63'h0, host_irq}, 64'h1, "R4 pulse");
        @(negedge clk);
        chk({63'h0, host_irq}, 64'h0, "R4 pulse ends");
        cyc(5);
        chk({63'h0, host_irq}, 64'h0, "R4 stays low until EOI");

        // R5: EOI with summary still set re-fires next cycle
        @(negedge clk); mst_wr = 1'b1; mst_wdata = 32'h2000;
        @(negedge clk); mst_wr = 1'b0; mst_wdata = '0;
        chk({63'h0, host_irq}, 64'h1, "R5 re-fire after EOI");
        chk({32'h0, mst_rdata}, 64'h0, "R6 EOI reads 0");
        pin_pend = '0;
        cyc(3);
        mwrite(32'h2000);
        cyc(3);
        chk({63'h0, host_irq}, 64'h0, "R5 EOI with empty summary");

        // R7: window of 3 ticks
        mwrite(32'h1003);
        chk({32'h0, mst_rdata}, 64'h1003, "R6 readback");
        pin_pend[40] = 1'b1;
        dwrite(100);
        cyc(2);
        chk({63'h0, en_block}, 64'h1, "R7 window open");
        chk({sum_hi, sum_lo}, 64'h0, "R7 pending ignored");
        cyc(20);
        chk({63'h0, en_block}, 64'h0, "R7 window closed");
        chk({32'h0, sum_lo}, 64'h400, "R7 status resumes");
        pin_pend = '0;
        mwrite(32'h2000);

        // R9: reload during window
        mwrite(32'h1008);
        dwrite(3);
        cyc(20);
        dwrite(150);
        cyc(20);
        chk({63'h0, en_block}, 64'h1, "R9 reload extends window");
        cyc(40);
        chk({63'h0, en_block}, 64'h0, "R9 window ends");

        // R8: block-enable clear
        mwrite(32'h0008);
        dwrite(10);
        cyc(2);
        chk({63'h0, en_block}, 64'h0, "R8 no window when disabled");

        // R10: zero length
        mwrite(32'h1000);
        dwrite(11);
        cyc(2);
        chk({63'h0, en_block}, 64'h0, "R10 no window with length 0");

        // Random phase against the model
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if ($urandom_range(0, 7) == 0) begin
                logic [191:0] r;
                for (int k = 0; k < 6; k++) r[k*32 +: 32] = $urandom & $urandom & $urandom;
                pin_pend = r[NP-1:0];
            end
            dbnc_wr = '0;
            if ($urandom_range(0, 40) == 0) dbnc_wr[$urandom_range(0, NP-1)] = 1'b1;
            mst_wr = 1'b0; mst_wdata = '0;
            if ($urandom_range(0, 9) == 0) begin
                mst_wr = 1'b1;
                mst_wdata = {18'h0, 1'($urandom), 1'($urandom_range(0, 3) != 0),
                             12'($urandom_range(0, 5))};
            end
        end
        @(negedge clk); mst_wr = 1'b0; dbnc_wr = '0;
        cyc(2);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule